// File: doc/BRIEF.md
# Delegated Interrupt Priority Selector

This block decides, once per clock, whether the core must take an interrupt and which cause number to report for it. It forms the live pending vector from the pending and enable masks and splits it into two groups using the delegation mask. Bits not delegated form the machine group. Delegated bits form the supervisor group. Each group has its own enable rule, which depends on the current privilege level and on that level's global interrupt-enable bit. The machine group is examined first. Inside the chosen group the lowest-numbered pending bit wins.

The block also owns the machine timer pending bit. A two-state timer machine raises that bit when the running time count reaches the compare value, and drops it when the compare value is rewritten. The decision is registered, so the trap sequencer sees a clean strobe and a full-width cause word one cycle after the inputs that produced them. The strobe is held off while the sequencer reports a trap already in progress.

Timer machine states: `TMR_IDLE` (bit clear) and `TMR_FIRED` (bit set). Transitions: `TMR_IDLE -> TMR_FIRED` when time >= compare and no compare write is present. `TMR_FIRED -> TMR_IDLE` on a compare write. `TMR_IDLE` stays put on a compare write, even if the count has already been reached. `TMR_FIRED` stays put otherwise.

Top module: `irq_select_top`

## Requirements
- R1: During reset and directly after it, `take_o` is 0, `cause_o` is 0 and `mtip_o` is 0.
- R2: A bit counts as pending only when it is set in both `pend_i` and `en_i`. A bit set in only one of them never produces a take.
- R3: Privilege is encoded user=0, supervisor=1, machine=3. The machine group (pending bits whose `deleg_i` bit is 0) is taken when privilege is below 3, or when privilege is 3 and `m_ie_i` is 1.
- R4: The supervisor group (pending bits whose `deleg_i` bit is 1) is taken when privilege is 0, or when privilege is 1 and `s_ie_i` is 1. It is never taken at privilege 3.
- R5: When both groups qualify, the cause comes from the machine group, even if the supervisor group holds a lower bit index.
- R6: The reported cause is the index of the lowest set bit of the chosen group, placed in the low bits of an XLEN-wide word with bit XLEN-1 set. `cause_o` is 0 whenever `take_o` is 0.
- R7: Bit 7 is the machine timer bit. Its value in `pend_i` is ignored and replaced by `mtip_o`. `mtip_o` rises one cycle after time >= compare is seen, and holds until a compare write. The compare write clears it one cycle later and wins when it falls in the same cycle as a reach.
- R8: While `busy_i` is 1, `take_o` is 0 in the next cycle.
- R9: `take_o` and `cause_o` reflect the inputs and the `mtip_o` value of the previous clock cycle (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | NIRQ | Pending mask (bit 7 ignored) |
| en_i | input | NIRQ | Per-interrupt enable mask |
| deleg_i | input | NIRQ | Delegation mask, 1 = supervisor group |
| priv_i | input | 2 | Current privilege level |
| m_ie_i | input | 1 | Machine global interrupt enable |
| s_ie_i | input | 1 | Supervisor global interrupt enable |
| busy_i | input | 1 | Trap already in progress |
| time_i | input | TW | Running time count |
| cmp_i | input | TW | Timer compare value |
| cmp_wr_i | input | 1 | Compare register rewritten this cycle |
| take_o | output | 1 | Take-interrupt strobe |
| cause_o | output | XLEN | Cause word, top bit set |
| mtip_o | output | 1 | Machine timer pending bit |

## Verification
Two functions can act in the same cycle. A delegated and a non-delegated interrupt can both qualify, and a compare write can land in the cycle the count reaches the compare value. The bench provokes the first by raising a lower-numbered supervisor bit together with a higher-numbered machine bit at user privilege, and expects the machine cause. It provokes the second by asserting the compare write while time already exceeds the compare. It expects the timer bit to read 0 after that edge, and then to rise one cycle after the write is released.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic {
        TMR_IDLE  = 1'b0,
        TMR_FIRED = 1'b1
    } tmr_state_e;

    localparam int IDX_S_SOFT  = 1;
    localparam int IDX_H_SOFT  = 2;
    localparam int IDX_M_SOFT  = 3;
    localparam int IDX_S_TIMER = 5;
    localparam int IDX_H_TIMER = 6;
    localparam int IDX_M_TIMER = 7;
    localparam int IDX_COPROC  = 8;
    localparam int IDX_HOST    = 9;
endpackage

// File: rtl/irq_timer_fsm.sv
module irq_timer_fsm
    import irq_pkg::*;
#(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_i,
    input  logic [TW-1:0] cmp_i,
    input  logic          cmp_wr_i,
    output logic          mtip_o
);
    tmr_state_e state_q, state_d;
    logic       reached;

    assign reached = (time_i >= cmp_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE:  if (reached && !cmp_wr_i) state_d = TMR_FIRED;
            TMR_FIRED: if (cmp_wr_i)             state_d = TMR_IDLE;
            default:                             state_d = TMR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            TMR_FIRED: mtip_o = 1'b1;
            default:   mtip_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/irq_select_top.sv
module irq_select_top
    import irq_pkg::*;
#(
    parameter int NIRQ = 16,
    parameter int XLEN = 64,
    parameter int TW   = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] pend_i,
    input  logic [NIRQ-1:0] en_i,
    input  logic [NIRQ-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            m_ie_i,
    input  logic            s_ie_i,
    input  logic            busy_i,
    input  logic [TW-1:0]   time_i,
    input  logic [TW-1:0]   cmp_i,
    input  logic            cmp_wr_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o,
    output logic            mtip_o
);
    localparam int IW     = $clog2(NIRQ);
    localparam int NGRP   = 2;
    localparam int GRP_M  = 0;
    localparam int GRP_S  = 1;
    localparam int PAD_W  = XLEN - 1 - IW;
    localparam logic [NIRQ-1:0] TMR_MASK = NIRQ'(1) << IDX_M_TIMER;

    logic            mtip;
    logic [NIRQ-1:0] live;
    logic [NIRQ-1:0] grp_vec [NGRP];
    logic            grp_ok  [NGRP];
    logic            grp_any [NGRP];
    logic [IW-1:0]   grp_idx [NGRP];
    logic            take_d;
    logic [IW-1:0]   idx_d;
    logic            take_q;
    logic [XLEN-1:0] cause_q;
    priv_e           priv;

    irq_timer_fsm #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .time_i   (time_i),
        .cmp_i    (cmp_i),
        .cmp_wr_i (cmp_wr_i),
        .mtip_o   (mtip)
    );

    assign priv = priv_e'(priv_i);
    assign live = ((pend_i & ~TMR_MASK) | (mtip ? TMR_MASK : '0)) & en_i;

    assign grp_vec[GRP_M] = live & ~deleg_i;
    assign grp_vec[GRP_S] = live &  deleg_i;
    assign grp_ok[GRP_M]  = (priv < PRIV_MACH)  || (priv == PRIV_MACH  && m_ie_i);
    assign grp_ok[GRP_S]  = (priv < PRIV_SUPER) || (priv == PRIV_SUPER && s_ie_i);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        irq_lowest_pick #(.N(NIRQ), .IW(IW)) u_pick (
            .vec_i (grp_vec[g]),
            .any_o (grp_any[g]),
            .idx_o (grp_idx[g])
        );
    end

    always_comb begin
        take_d = 1'b0;
        idx_d  = '0;
        if (grp_ok[GRP_M] && grp_any[GRP_M]) begin
            take_d = 1'b1;
            idx_d  = grp_idx[GRP_M];
        end else if (grp_ok[GRP_S] && grp_any[GRP_S]) begin
            take_d = 1'b1;
            idx_d  = grp_idx[GRP_S];
        end
        if (busy_i) take_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q  <= 1'b0;
            cause_q <= '0;
        end else begin
            take_q  <= take_d;
            cause_q <= take_d ? {1'b1, {PAD_W{1'b0}}, idx_d} : '0;
        end
    end

    assign take_o  = take_q;
    assign cause_o = cause_q;
    assign mtip_o  = mtip;
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
    parameter int XLEN = 64,
    parameter int TW   = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      priv_i,
    input logic            m_ie_i,
    input logic            busy_i,
    input logic [TW-1:0]   time_i,
    input logic [TW-1:0]   cmp_i,
    input logic            cmp_wr_i,
    input logic            take_o,
    input logic [XLEN-1:0] cause_o,
    input logic            mtip_o
);
    // R6
    take_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> cause_o[XLEN-1]);

    // R6
    idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0));

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !take_o);

    // R4
    mach_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == 2'd3 && !m_ie_i) |=> !take_o);

    // R7
    cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_i |=> !mtip_o);

    // R7
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mtip_o && !cmp_wr_i) |=> mtip_o);

    // R7
    tmr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mtip_o && (time_i < cmp_i)) |=> !mtip_o);
endmodule

bind irq_select_top irq_select_chk #(.XLEN(XLEN), .TW(TW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .priv_i   (priv_i),
    .m_ie_i   (m_ie_i),
    .busy_i   (busy_i),
    .time_i   (time_i),
    .cmp_i    (cmp_i),
    .cmp_wr_i (cmp_wr_i),
    .take_o   (take_o),
    .cause_o  (cause_o),
    .mtip_o   (mtip_o)
);

// File: tb/tb_irq_select_top.sv
module tb_irq_select_top;
    localparam int CLK_P = 10;
    localparam int NIRQ  = 16;
    localparam int XLEN  = 64;
    localparam int TW    = 64;
    localparam logic [XLEN-1:0] MSB = {1'b1, {(XLEN-1){1'b0}}};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] pend_i = '0;
    logic [NIRQ-1:0] en_i = '0;
    logic [NIRQ-1:0] deleg_i = '0;
    logic [1:0]      priv_i = 2'd3;
    logic            m_ie_i = 1'b0;
    logic            s_ie_i = 1'b0;
    logic            busy_i = 1'b0;
    logic [TW-1:0]   time_i = '0;
    logic [TW-1:0]   cmp_i = '1;
    logic            cmp_wr_i = 1'b0;
    logic            take_o;
    logic [XLEN-1:0] cause_o;
    logic            mtip_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    irq_select_top #(.NIRQ(NIRQ), .XLEN(XLEN), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i),
        .deleg_i(deleg_i), .priv_i(priv_i), .m_ie_i(m_ie_i), .s_ie_i(s_ie_i),
        .busy_i(busy_i), .time_i(time_i), .cmp_i(cmp_i), .cmp_wr_i(cmp_wr_i),
        .take_o(take_o), .cause_o(cause_o), .mtip_o(mtip_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_take(string req, logic exp_t, int exp_idx);
        logic [XLEN-1:0] exp_c;
        exp_c = exp_t ? (MSB | XLEN'(exp_idx)) : '0;
        n_run++;
        if (take_o !== exp_t || cause_o !== exp_c) begin
            n_fail++;
            $display("FAIL %s take=%b cause=%h expected take=%b cause=%h",
                     req, take_o, cause_o, exp_t, exp_c);
        end
    endtask

    task automatic chk_tmr(string req, logic exp_m);
        n_run++;
        if (mtip_o !== exp_m) begin
            n_fail++;
            $display("FAIL %s mtip=%b expected %b", req, mtip_o, exp_m);
        end
    endtask

    task automatic clear_in();
        pend_i = '0; en_i = '0; deleg_i = '0; busy_i = 1'b0;
        m_ie_i = 1'b0; s_ie_i = 1'b0; priv_i = 2'd3; cmp_wr_i = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        chk_take("R1 reset", 1'b0, 0);
        chk_tmr("R1 reset", 1'b0);
        rst_n = 1'b1;
        tick();
        chk_take("R1 after reset", 1'b0, 0);
        chk_tmr("R1 after reset", 1'b0);
    endtask

    task automatic t_mask();
        clear_in();
        priv_i = 2'd3; m_ie_i = 1'b1;
        pend_i[3] = 1'b1;
        tick();
        chk_take("R2 pending not enabled", 1'b0, 0);
        pend_i = '0; en_i[3] = 1'b1;
        tick();
        chk_take("R2 enabled not pending", 1'b0, 0);
        pend_i[3] = 1'b1;
        tick();
        chk_take("R3 machine at M with enable", 1'b1, 3);
    endtask

    task automatic t_mgate();
        clear_in();
        pend_i[9] = 1'b1; en_i[9] = 1'b1;
        priv_i = 2'd3; m_ie_i = 1'b0;
        tick();
        chk_take("R3 machine at M gated off", 1'b0, 0);
        priv_i = 2'd1;
        tick();
        chk_take("R3 machine from S ignores enable", 1'b1, 9);
        priv_i = 2'd0;
        tick();
        chk_take("R3 machine from U", 1'b1, 9);
    endtask

    task automatic t_sgroup();
        clear_in();
        pend_i[1] = 1'b1; en_i[1] = 1'b1; deleg_i[1] = 1'b1;
        priv_i = 2'd3; m_ie_i = 1'b1; s_ie_i = 1'b1;
        tick();
        chk_take("R4 supervisor never at M", 1'b0, 0);
        priv_i = 2'd1; s_ie_i = 1'b0;
        tick();
        chk_take("R4 supervisor at S gated off", 1'b0, 0);
        s_ie_i = 1'b1;
        tick();
        chk_take("R4 supervisor at S enabled", 1'b1, 1);
        priv_i = 2'd0; s_ie_i = 1'b0;
        tick();
        chk_take("R4 supervisor from U", 1'b1, 1);
    endtask

    task automatic t_prio();
        clear_in();
        priv_i = 2'd0;
        pend_i = 16'h020A; en_i = 16'h020A; deleg_i = 16'h0002;
        tick();
        chk_take("R5 machine group first", 1'b1, 3);
        pend_i = 16'h0220; en_i = 16'h0220; deleg_i = '0;
        tick();
        chk_take("R6 lowest machine bit", 1'b1, 5);
        pend_i = 16'h0062; en_i = 16'h0062; deleg_i = 16'h0062;
        tick();
        chk_take("R6 lowest supervisor bit", 1'b1, 1);
    endtask

    task automatic t_busy();
        clear_in();
        priv_i = 2'd0; pend_i[8] = 1'b1; en_i[8] = 1'b1; busy_i = 1'b1;
        tick();
        chk_take("R8 busy holds strobe off", 1'b0, 0);
        busy_i = 1'b0;
        tick();
        chk_take("R8 strobe after busy", 1'b1, 8);
    endtask

    task automatic t_timer();
        clear_in();
        priv_i = 2'd0; en_i[7] = 1'b1; pend_i[7] = 1'b1;
        cmp_i = 64'd100; time_i = 64'd10;
        tick();
        tick();
        chk_take("R7 pend bit 7 ignored", 1'b0, 0);
        chk_tmr("R7 below compare", 1'b0);
        pend_i = '0;
        time_i = 64'd100;
        tick();
        chk_tmr("R7 rises on reach", 1'b1);
        chk_take("R9 one cycle behind timer", 1'b0, 0);
        tick();
        chk_take("R7 timer taken", 1'b1, 7);
        time_i = 64'd50;
        tick();
        chk_tmr("R7 holds below compare", 1'b1);
        cmp_i = 64'd200; cmp_wr_i = 1'b1;
        tick();
        chk_tmr("R7 cleared by compare write", 1'b0);
        cmp_wr_i = 1'b0;
        tick();
        chk_take("R9 take follows clear", 1'b0, 0);
        time_i = 64'd300; cmp_wr_i = 1'b1;
        tick();
        chk_tmr("R7 write beats reach", 1'b0);
        cmp_wr_i = 1'b0;
        tick();
        chk_tmr("R7 reach after write", 1'b1);
        cmp_i = '1; cmp_wr_i = 1'b1;
        tick();
        cmp_wr_i = 1'b0;
    endtask

    task automatic t_latency();
        clear_in();
        priv_i = 2'd0; en_i[2] = 1'b1;
        pend_i[2] = 1'b1;
        #2;
        chk_take("R9 no change before edge", 1'b0, 0);
        tick();
        chk_take("R9 change after edge", 1'b1, 2);
        pend_i[2] = 1'b0;
        tick();
        chk_take("R9 drop after edge", 1'b0, 0);
    endtask

    initial begin
        tick();
        tick();
        t_reset();
        t_mask();
        t_mgate();
        t_sgroup();
        t_prio();
        t_busy();
        t_timer();
        t_latency();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule